// File: doc/BRIEF.md
# Dual-Channel UART Host Register Interface

This block is the processor-facing register file of a two-channel UART. For each channel it holds a line-control byte, a control byte, a status byte, a one-entry receive buffer, a one-entry transmit holding register and a 16-bit baud divisor. Serialisation, line sampling and baud generation sit outside it. Received bytes come in on a valid/ready byte stream and transmitted bytes leave on a second one.

Software configures a channel by writing its registers over a simple synchronous strobe bus. It polls the status byte or takes the single-cycle interrupt pulses toward the interrupt controller. The control byte decides whether a pulse is produced.

Status bits 3:0 clear when software reads them, and data-ready also clears when the receive buffer is read. A received byte that arrives before the previous one was collected overwrites it and sets an overrun flag.

Top module: `uart_host_regs`

## Requirements
- R1: After reset every status byte reads 0x00C0 and every other register reads 0. No transmit byte is offered and no interrupt pulse is active.
- R2: The address is formed from a channel field and a register field. Bit 3 selects the channel. Bits 2:0 select the register: 0 line control (8 bits), 1 control (8 bits), 2 status, 3 transmit buffer (write only), 4 receive buffer, 5 divisor (16 bits). Writes to line control, control and divisor read back truncated to the register width. Any other register field reads 0. Read data appears on `rdata` in the cycle after the `rd_en` edge.
- R3: A byte accepted on a channel's receive stream is stored in that channel's receive buffer, and status bit 0 (data ready) is set.
- R4: Reading the receive buffer returns the stored byte and clears status bit 0.
- R5: Reading status returns its value as it was before the read, and then clears status bits 3:0.
- R6: A byte arriving while status bit 0 is set replaces the buffered byte and sets status bit 1 (overrun).
- R7: A receive interrupt pulse of exactly one cycle is produced in the cycle after an arrival, and only when control bits 1:0 equal 01.
- R8: Writing the transmit buffer while nothing is pending offers the low byte of `wdata` on the transmit stream and clears status bits 7:6 until the byte is taken.
- R9: When the transmit stream accepts the byte, status bits 6 (holding empty) and 7 (transmitter empty) are set. A one-cycle transmit interrupt pulse follows in the next cycle, and only when control bits 3:2 equal 11.
- R10: A transmit-buffer write while a byte is still pending is ignored, and the offered byte stays unchanged.
- R11: The two channels are independent. Accesses, arrivals and modes on one channel leave the other's registers and pulses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Channel (bit 3) and register field (bits 2:0) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rx_valid | input | 2 | Receive stream valid, one per channel |
| rx_data | input | 16 | Receive bytes, channel n in bits 8n+7:8n |
| rx_ready | output | 2 | Receive stream ready, always high |
| tx_valid | output | 2 | Transmit stream valid, one per channel |
| tx_data | output | 16 | Transmit bytes, channel n in bits 8n+7:8n |
| tx_ready | input | 2 | Transmit stream ready |
| rx_irq | output | 2 | Receive interrupt pulses |
| tx_irq | output | 2 | Transmit interrupt pulses |

## Verification
- **Read data:** due one edge after the read strobe.
- **Receive results:** data ready, overrun and the receive pulse all appear one edge after an arrival.
- **Transmit write:** the transmit byte and the cleared empty flags appear one edge after the buffer write.
- **Transmit handshake:** the set empty flags and the transmit pulse appear one edge after the handshake.

The bench drives every input on the falling edge and samples on the falling edge that follows the causing rising edge. It then checks the next falling edge to confirm each interrupt pulse has already dropped.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] OFF_LINE = 3'd0;
  localparam logic [SEL_W-1:0] OFF_CTRL = 3'd1;
  localparam logic [SEL_W-1:0] OFF_STAT = 3'd2;
  localparam logic [SEL_W-1:0] OFF_TXB  = 3'd3;
  localparam logic [SEL_W-1:0] OFF_RXB  = 3'd4;
  localparam logic [SEL_W-1:0] OFF_DIV  = 3'd5;

  localparam int ST_RDY  = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_HEMP = 6;
  localparam int ST_TEMP = 7;
  localparam logic [7:0] STAT_RST = 8'hC0;

  localparam logic [1:0] RXI_MODE = 2'b01;
  localparam logic [1:0] TXI_MODE = 2'b11;
endpackage

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_regs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 16,
  parameter int BW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [BW-1:0]    wdata,
  output logic [BW-1:0]    rd_val,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_ready,
  output logic             rx_irq,
  output logic             tx_irq
);
  logic [7:0]      line_q, ctrl_q, stat_q, stat_d;
  logic [DW-1:0]   rxbuf_q, txbuf_q;
  logic [DIVW-1:0] div_q;
  logic            pend_q, pend_d, rxi_q, rxi_d, txi_q, txi_d;
  logic            line_we, ctrl_we, div_we, tx_load, tx_fire, rx_fire;

  assign rx_ready = 1'b1;
  assign rx_fire  = rx_valid;
  assign tx_fire  = pend_q && tx_ready;
  assign line_we  = wr_en && (reg_sel == OFF_LINE);
  assign ctrl_we  = wr_en && (reg_sel == OFF_CTRL);
  assign div_we   = wr_en && (reg_sel == OFF_DIV);
  assign tx_load  = wr_en && (reg_sel == OFF_TXB) && !pend_q;

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    if (rd_en && reg_sel == OFF_STAT) stat_d[3:0] = 4'h0;
    if (rd_en && reg_sel == OFF_RXB)  stat_d[ST_RDY] = 1'b0;
    if (rx_fire) begin
      if (stat_d[ST_RDY]) stat_d[ST_OVR] = 1'b1;
      stat_d[ST_RDY] = 1'b1;
    end
    if (tx_load) begin
      pend_d = 1'b1;
      stat_d[ST_HEMP] = 1'b0;
      stat_d[ST_TEMP] = 1'b0;
    end else if (tx_fire) begin
      pend_d = 1'b0;
      stat_d[ST_HEMP] = 1'b1;
      stat_d[ST_TEMP] = 1'b1;
    end
    rxi_d = rx_fire && (ctrl_q[1:0] == RXI_MODE);
    txi_d = tx_fire && (ctrl_q[3:2] == TXI_MODE);
  end

  always_comb begin
    case (reg_sel)
      OFF_LINE: rd_val = BW'(line_q);
      OFF_CTRL: rd_val = BW'(ctrl_q);
      OFF_STAT: rd_val = BW'(stat_q);
      OFF_RXB:  rd_val = BW'(rxbuf_q);
      OFF_DIV:  rd_val = BW'(div_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      ctrl_q  <= '0;
      div_q   <= '0;
      rxbuf_q <= '0;
      txbuf_q <= '0;
      stat_q  <= STAT_RST;
      pend_q  <= 1'b0;
      rxi_q   <= 1'b0;
      txi_q   <= 1'b0;
    end else begin
      if (line_we) line_q  <= wdata[7:0];
      if (ctrl_we) ctrl_q  <= wdata[7:0];
      if (div_we)  div_q   <= wdata[DIVW-1:0];
      if (rx_fire) rxbuf_q <= rx_data;
      if (tx_load) txbuf_q <= wdata[DW-1:0];
      stat_q <= stat_d;
      pend_q <= pend_d;
      rxi_q  <= rxi_d;
      txi_q  <= txi_d;
    end
  end

  assign tx_valid = pend_q;
  assign tx_data  = txbuf_q;
  assign rx_irq   = rxi_q;
  assign tx_irq   = txi_q;

  // R5
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == OFF_STAT && !rx_valid) |=> (stat_q[3:0] == 4'h0));
  // R3
  rx_ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> stat_q[ST_RDY]);
  // R7
  rx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> ($past(rx_valid) && $past(ctrl_q[1:0]) == RXI_MODE));
  // R9
  tx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> ($past(tx_valid) && $past(tx_ready)));
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter  int NCH  = 2,
  parameter  int DW   = 8,
  parameter  int DIVW = 16,
  localparam int CW   = $clog2(NCH),
  localparam int AW   = CW + SEL_W,
  localparam int BW   = (DIVW > 8) ? DIVW : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  input  logic [NCH-1:0]    rx_valid,
  input  logic [NCH*DW-1:0] rx_data,
  output logic [NCH-1:0]    rx_ready,
  output logic [NCH-1:0]    tx_valid,
  output logic [NCH*DW-1:0] tx_data,
  input  logic [NCH-1:0]    tx_ready,
  output logic [NCH-1:0]    rx_irq,
  output logic [NCH-1:0]    tx_irq
);
  logic [1:0]    rs_q;
  logic          srst_n;
  logic [CW-1:0] chan;
  logic [BW-1:0] rv [NCH];
  logic [BW-1:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];
  assign chan   = addr[AW-1:SEL_W];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = (int'(chan) == i);
    uart_chan_regs #(.DW(DW), .DIVW(DIVW), .BW(BW)) u_ch (
      .clk      (clk),
      .rst_n    (srst_n),
      .wr_en    (wr_en && hit),
      .rd_en    (rd_en && hit),
      .reg_sel  (addr[SEL_W-1:0]),
      .wdata    (wdata),
      .rd_val   (rv[i]),
      .rx_valid (rx_valid[i]),
      .rx_data  (rx_data[i*DW +: DW]),
      .rx_ready (rx_ready[i]),
      .tx_valid (tx_valid[i]),
      .tx_data  (tx_data[i*DW +: DW]),
      .tx_ready (tx_ready[i]),
      .rx_irq   (rx_irq[i]),
      .tx_irq   (tx_irq[i])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (int'(chan) < NCH) rdata_d = rv[chan];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end
endmodule

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
  logic        clk, rst_n, wr_en, rd_en;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;
  logic [1:0]  rx_valid, rx_ready, tx_valid, tx_ready, rx_irq, tx_irq;
  logic [15:0] rx_data, tx_data;
  int n_cmp = 0, n_bad = 0;

  uart_host_regs u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {is_write, addr, data, expected read}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 4'h0, 16'hFF2B, 16'h0000},
    {1'b1, 4'h1, 16'h000D, 16'h0000},
    {1'b1, 4'h5, 16'h1234, 16'h0000},
    {1'b1, 4'h8, 16'h0003, 16'h0000},
    {1'b1, 4'h9, 16'h0000, 16'h0000},
    {1'b1, 4'hD, 16'hBEEF, 16'h0000},
    {1'b0, 4'h0, 16'h0000, 16'h002B},
    {1'b0, 4'h1, 16'h0000, 16'h000D},
    {1'b0, 4'h5, 16'h0000, 16'h1234},
    {1'b0, 4'h8, 16'h0000, 16'h0003},
    {1'b0, 4'h9, 16'h0000, 16'h0000},
    {1'b0, 4'hD, 16'h0000, 16'hBEEF},
    {1'b0, 4'hA, 16'h0000, 16'h00C0},
    {1'b0, 4'h6, 16'h0000, 16'h0000}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rx(input int ch, input logic [7:0] b);
    @(negedge clk); rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = b;
    @(posedge clk);
    @(negedge clk); rx_valid[ch] = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rx_valid = '0; rx_data = '0; tx_ready = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'h2, v); chk("R1 ch0 status", v, 16'h00C0);
    rd(4'hA, v); chk("R1 ch1 status", v, 16'h00C0);
    rd(4'h4, v); chk("R1 ch0 rx buffer", v, 16'h0000);
    rd(4'h5, v); chk("R1 ch0 divisor", v, 16'h0000);
    chk("R1 tx_valid", {14'd0, tx_valid}, 16'h0);
    chk("R1 irqs", {12'd0, rx_irq, tx_irq}, 16'h0);

    // R2 table of register writes and read-backs
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36]) wr(VEC[i][35:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][35:32], v);
        chk($sformatf("R2 vector %0d", i), v, VEC[i][15:0]);
      end
    end

    // R3 / R7 arrival on ch0 (receive mode 01)
    rx(0, 8'h5A);
    chk("R7 rx pulse ch0", {14'd0, rx_irq}, 16'h0001);
    @(negedge clk);
    chk("R7 rx pulse one cycle", {14'd0, rx_irq}, 16'h0000);
    rd(4'h2, v); chk("R3 status data ready", v, 16'h00C1);
    rd(4'h2, v); chk("R5 status low bits cleared", v, 16'h00C0);
    rd(4'h4, v); chk("R3 rx buffer", v, 16'h005A);

    // R6 overrun
    rx(0, 8'h66);
    rx(0, 8'h77);
    rd(4'h4, v); chk("R6 rx buffer overwritten", v, 16'h0077);
    rd(4'h2, v); chk("R6 overrun set, R4 ready cleared", v, 16'h00C2);
    rd(4'h2, v); chk("R5 overrun cleared", v, 16'h00C0);

    // R4
    rx(0, 8'h11);
    rd(4'h4, v); chk("R4 rx buffer read", v, 16'h0011);
    rd(4'h2, v); chk("R4 data ready cleared", v, 16'h00C0);

    // R7 / R11 ch1 has receive mode 00
    rx(1, 8'h33);
    chk("R7 no pulse in mode 00", {14'd0, rx_irq}, 16'h0000);
    rd(4'h2, v); chk("R11 ch0 status untouched", v, 16'h00C0);
    rd(4'hA, v); chk("R11 ch1 status", v, 16'h00C1);
    rd(4'hC, v); chk("R11 ch1 rx buffer", v, 16'h0033);

    // R8 / R10 / R9 transmit on ch0 (transmit mode 11)
    wr(4'h3, 16'h01A5);
    chk("R8 tx_valid", {14'd0, tx_valid}, 16'h0001);
    chk("R8 tx byte", {8'd0, tx_data[7:0]}, 16'h00A5);
    rd(4'h2, v); chk("R8 empty flags cleared", v, 16'h0000);
    wr(4'h3, 16'h003C);
    chk("R10 pending byte kept", {8'd0, tx_data[7:0]}, 16'h00A5);
    @(negedge clk); tx_ready = 2'b11;
    @(negedge clk);
    chk("R9 tx pulse ch0", {14'd0, tx_irq}, 16'h0001);
    chk("R9 tx_valid dropped", {14'd0, tx_valid}, 16'h0000);
    @(negedge clk);
    chk("R9 tx pulse one cycle", {14'd0, tx_irq}, 16'h0000);
    rd(4'h2, v); chk("R9 empty flags set", v, 16'h00C0);

    // R9 / R11 ch1 transmit mode 00
    wr(4'hB, 16'h0099);
    chk("R8 ch1 tx byte", {8'd0, tx_data[15:8]}, 16'h0099);
    @(negedge clk);
    chk("R9 ch1 accepted", {14'd0, tx_valid}, 16'h0000);
    chk("R9 ch1 no pulse", {14'd0, tx_irq}, 16'h0000);
    rd(4'hA, v); chk("R9 ch1 empty flags", v, 16'h00C0);

    summary();
    $finish;
  end
endmodule